// File: doc/BRIEF.md
# Pixel Receiver with Frame/Line Tagging

This block sits in the receive clock domain behind the line receivers of a parallel pixel link. Each cycle with a valid input it compares the incoming 16-bit word against three programmable control patterns: a synchronisation pattern, a preamble pattern and an idle pattern. A match is never stored. Instead, a sync or preamble match arms a pending frame mark, and an idle match arms a pending line mark.

The next data pixel carries the pending marks in its two top bits and clears them. Tagged pixels are paired into 32-bit words and pushed into the downstream receive FIFO. A configuration bit selects which half of the word holds the earlier pixel.

If the FIFO reports full when a word completes, the word is dropped. A sticky overflow flag then stays set until reset.

Top module: `pixel_tagger`

## Requirements
- R1: After reset `fifo_wr` and `overflow` are 0, no mark is pending, and the packer starts with an empty lower slot, so the first two data pixels form one unmarked word.
- R2: An input equal to `cfg_sync` is not stored. The next data pixel has bit 15 set to 1.
- R3: An input equal to `cfg_pre` is not stored. The next data pixel has bit 15 set to 1.
- R4: An input equal to `cfg_idle` is not stored. The next data pixel has bit 14 set to 1, however many idles came before it.
- R5: A data pixel's bits 13:0 pass unchanged. Its bits 15 and 14 carry only the pending marks, which are then cleared, so later pixels have both bits at 0.
- R6: Control patterns never take a slot in a packed word. Only data pixels (inputs that match no pattern) are counted toward a word.
- R7: When `cfg_idle` equals `cfg_sync`, that input arms both marks, so the next data pixel has bits 15 and 14 both set to 1.
- R8: `fifo_wr` pulses for exactly one cycle. The pulse follows the clock edge that accepts the second data pixel of a pair. With `cfg_swap`=0, the first pixel goes in bits 15:0 and the second in bits 31:16.
- R9: With `cfg_swap`=1, the first pixel goes in bits 31:16 and the second in bits 15:0.
- R10: If `fifo_full` is 1 on the edge that completes a word, no write occurs and the word is lost. `overflow` becomes 1 and holds until reset.
- R11: While `in_valid` is 0, the input value has no effect on marks, packing or outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present this cycle |
| in_pixel | input | 16 | Received word |
| cfg_sync | input | 16 | Sync pattern (frame mark) |
| cfg_pre | input | 16 | Preamble pattern (frame mark) |
| cfg_idle | input | 16 | Idle pattern (line mark) |
| cfg_swap | input | 1 | 1 places the earlier pixel in the upper half |
| fifo_full | input | 1 | Receive FIFO cannot accept a word |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 32 | Packed word |
| overflow | output | 1 | Sticky: a completed word was dropped |

## Verification
Marks take no cycles of their own. They appear inside the word that is written, and that word becomes visible one clock edge after its second data pixel is accepted. `overflow` rises on that same edge. The bench drives one input per cycle on the falling edge. After each rising edge it compares `fifo_wr`, `fifo_data` and `overflow` against a model of the requirements, so every result is checked in the cycle it is due and a late or early write counts as a failure.

// File: rtl/pxt_pkg.sv
package pxt_pkg;
    localparam int PIX_W  = 16;
    localparam int WORD_W = 2 * PIX_W;
    localparam int FRM_B  = PIX_W - 1;
    localparam int LIN_B  = PIX_W - 2;

    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic is_frame;
        logic is_line;
        logic is_ctrl;
    } cls_t;

    function automatic pix_t apply_marks(pix_t p, logic frm, logic lin);
        pix_t r;
        r        = p;
        r[FRM_B] = frm;
        r[LIN_B] = lin;
        return r;
    endfunction

    function automatic word_t pack_pair(pix_t earlier, pix_t later, logic swap);
        return swap ? {earlier, later} : {later, earlier};
    endfunction
endpackage

// File: rtl/pxt_classify.sv
module pxt_classify
    import pxt_pkg::*;
(
    input  pix_t pix,
    input  pix_t pat_sync,
    input  pix_t pat_pre,
    input  pix_t pat_idle,
    output cls_t cls
);
    logic hit_sync, hit_pre, hit_idle;

    always_comb begin
        hit_sync     = (pix == pat_sync);
        hit_pre      = (pix == pat_pre);
        hit_idle     = (pix == pat_idle);
        cls.is_frame = hit_sync | hit_pre;
        cls.is_line  = hit_idle;
        cls.is_ctrl  = hit_sync | hit_pre | hit_idle;
    end
endmodule

// File: rtl/pxt_marker.sv
module pxt_marker
    import pxt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  pix_t in_pixel,
    input  cls_t cls,
    output logic px_valid,
    output pix_t px_data
);
    logic frame_pend, line_pend;

    always_comb begin
        px_valid = in_valid & ~cls.is_ctrl;
        px_data  = apply_marks(in_pixel, frame_pend, line_pend);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_pend <= 1'b0;
            line_pend  <= 1'b0;
        end else if (in_valid) begin
            if (cls.is_ctrl) begin
                if (cls.is_frame) frame_pend <= 1'b1;
                if (cls.is_line)  line_pend  <= 1'b1;
            end else begin
                frame_pend <= 1'b0;
                line_pend  <= 1'b0;
            end
        end
    end

    // R2
    frame_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cls.is_frame) |=> frame_pend);
    // R7
    both_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cls.is_frame && cls.is_line) |=> (frame_pend && line_pend));
    // R5
    marks_clear_chk: assert property (@(posedge clk) disable iff (rst)
        px_valid |=> (!frame_pend && !line_pend));
    // R11
    idle_input_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(frame_pend) && $stable(line_pend)));
endmodule

// File: rtl/pxt_packer.sv
module pxt_packer
    import pxt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  px_valid,
    input  pix_t  px_data,
    input  logic  cfg_swap,
    input  logic  fifo_full,
    output logic  fifo_wr,
    output word_t fifo_data,
    output logic  overflow
);
    logic have_first;
    pix_t first_px;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_first <= 1'b0;
            first_px   <= '0;
            fifo_wr    <= 1'b0;
            fifo_data  <= '0;
            overflow   <= 1'b0;
        end else begin
            fifo_wr <= 1'b0;
            if (px_valid) begin
                if (!have_first) begin
                    first_px   <= px_data;
                    have_first <= 1'b1;
                end else begin
                    have_first <= 1'b0;
                    if (fifo_full) begin
                        overflow <= 1'b1;
                    end else begin
                        fifo_wr   <= 1'b1;
                        fifo_data <= pack_pair(first_px, px_data, cfg_swap);
                    end
                end
            end
        end
    end

    // R10
    no_write_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> $past(px_valid && !fifo_full));
    // R10
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |=> !fifo_wr);
endmodule

// File: rtl/pixel_tagger.sv
module pixel_tagger
    import pxt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [PIX_W-1:0]    in_pixel,
    input  logic [PIX_W-1:0]    cfg_sync,
    input  logic [PIX_W-1:0]    cfg_pre,
    input  logic [PIX_W-1:0]    cfg_idle,
    input  logic                cfg_swap,
    input  logic                fifo_full,
    output logic                fifo_wr,
    output logic [WORD_W-1:0]   fifo_data,
    output logic                overflow
);
    cls_t cls;
    logic px_valid;
    pix_t px_data;

    pxt_classify u_classify (
        .pix      (in_pixel),
        .pat_sync (cfg_sync),
        .pat_pre  (cfg_pre),
        .pat_idle (cfg_idle),
        .cls      (cls)
    );

    pxt_marker u_marker (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_pixel (in_pixel),
        .cls      (cls),
        .px_valid (px_valid),
        .px_data  (px_data)
    );

    pxt_packer u_packer (
        .clk       (clk),
        .rst       (rst),
        .px_valid  (px_valid),
        .px_data   (px_data),
        .cfg_swap  (cfg_swap),
        .fifo_full (fifo_full),
        .fifo_wr   (fifo_wr),
        .fifo_data (fifo_data),
        .overflow  (overflow)
    );

    // R6
    ctrl_not_packed_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_pixel == cfg_sync) |=> !fifo_wr);
endmodule

// File: tb/pixel_tagger_tb.sv
module pixel_tagger_tb;
    import pxt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int STEPS      = 1500;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    pix_t        in_pixel;
    pix_t        cfg_sync, cfg_pre, cfg_idle;
    logic        cfg_swap;
    logic        fifo_full;
    logic        fifo_wr;
    word_t       fifo_data;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    logic  m_frm, m_lin, m_half, m_ovf;
    pix_t  m_first;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixel_tagger u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pixel(in_pixel),
        .cfg_sync(cfg_sync), .cfg_pre(cfg_pre), .cfg_idle(cfg_idle),
        .cfg_swap(cfg_swap), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
        .fifo_data(fifo_data), .overflow(overflow)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; in_pixel = '0; fifo_full = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_frm = 0; m_lin = 0; m_half = 0; m_ovf = 0; m_first = '0;
        check("R1 fifo_wr", {63'd0, fifo_wr}, 64'd0);
        check("R1 overflow", {63'd0, overflow}, 64'd0);
    endtask

    task automatic step(input logic v, input pix_t p, input logic full, input string tag);
        logic  exp_wr;
        word_t exp_word;
        pix_t  tp;
        @(negedge clk);
        in_valid = v; in_pixel = p; fifo_full = full;
        exp_wr = 1'b0; exp_word = '0;
        if (v) begin
            if (p == cfg_sync || p == cfg_pre || p == cfg_idle) begin
                if (p == cfg_sync || p == cfg_pre) m_frm = 1'b1;
                if (p == cfg_idle) m_lin = 1'b1;
            end else begin
                tp = {m_frm, m_lin, p[PIX_W-3:0]};
                m_frm = 1'b0; m_lin = 1'b0;
                if (!m_half) begin
                    m_first = tp; m_half = 1'b1;
                end else begin
                    m_half = 1'b0;
                    exp_word = cfg_swap ? {m_first, tp} : {tp, m_first};
                    if (full) m_ovf = 1'b1;
                    else exp_wr = 1'b1;
                end
            end
        end
        @(posedge clk);
        #1;
        check({tag, " fifo_wr"}, {63'd0, fifo_wr}, {63'd0, exp_wr});
        if (exp_wr) check({tag, " fifo_data"}, {32'd0, fifo_data}, {32'd0, exp_word});
        check({tag, " overflow"}, {63'd0, overflow}, {63'd0, m_ovf});
    endtask

    function automatic pix_t rand_data();
        pix_t d;
        d = pix_t'($urandom);
        while (d == cfg_sync || d == cfg_pre || d == cfg_idle) d = d + 1'b1;
        return d;
    endfunction

    task automatic random_run(input string tag);
        for (int i = 0; i < STEPS; i++) begin
            int sel;
            sel = $urandom_range(0, 9);
            case (sel)
                0: step(1'b1, cfg_sync, 1'b0, tag);
                1: step(1'b1, cfg_pre, 1'b0, tag);
                2: step(1'b1, cfg_idle, 1'b0, tag);
                3: step(1'b0, rand_data(), 1'b0, tag);
                4: step(1'b1, rand_data(), ($urandom_range(0, 7) == 0), tag);
                default: step(1'b1, rand_data(), 1'b0, tag);
            endcase
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cfg_sync = 16'hA5A5; cfg_pre = 16'h5A5A; cfg_idle = 16'h0F0F; cfg_swap = 1'b0;
        do_reset();
        // R1: first pair unmarked
        step(1, 16'hD234, 0, "R1"); step(1, 16'h4321, 0, "R1");
        // R2, R6: sync mark, sync not packed
        step(1, cfg_sync, 0, "R6"); step(1, 16'h1111, 0, "R2"); step(1, 16'h2222, 0, "R2");
        // R3
        step(1, cfg_pre, 0, "R3"); step(1, 16'h3333, 0, "R3"); step(1, 16'h4444, 0, "R3");
        // R4: repeated idles
        step(1, cfg_idle, 0, "R4"); step(1, cfg_idle, 0, "R4");
        step(1, 16'hFFF0, 0, "R4"); step(1, 16'h0001, 0, "R4");
        // R5: marks cleared
        step(1, 16'hC0DE, 0, "R5"); step(1, 16'hFFFF, 0, "R5");
        // R11: invalid sync and invalid data ignored
        step(0, cfg_sync, 0, "R11"); step(1, 16'h5555, 0, "R11");
        step(0, 16'h7777, 0, "R11"); step(1, 16'h6666, 0, "R11");
        // R10: drop when full, overflow sticks
        step(1, 16'h1234, 0, "R10"); step(1, 16'h5678, 1, "R10");
        step(1, 16'h9ABC, 0, "R10"); step(1, 16'hDEF0, 0, "R10");
        step(0, 16'h0000, 0, "R10");
        random_run("R8");

        cfg_swap = 1'b1;
        do_reset();
        step(1, cfg_sync, 0, "R9"); step(1, 16'h0AAA, 0, "R9"); step(1, 16'h0BBB, 0, "R9");
        random_run("R9");

        cfg_swap = 1'b0;
        cfg_idle = cfg_sync;
        do_reset();
        step(1, cfg_idle, 0, "R7"); step(1, 16'h0123, 0, "R7"); step(1, 16'h0456, 0, "R7");
        random_run("R7");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule